// File: doc/BRIEF.md
# I2C Master SCL Clock Generator with Per-Bit Line Synchronization

This block produces the SCL clock of an I2C master and keeps every bit in step with the level actually present on the wire. It pulls SCL low for a fixed count. It then releases the line to high impedance rather than driving it high. After a rate-dependent monitor delay it reads the line. The high phase is timed only from the first cycle the line reads high. A slave stretching the clock, or a heavily loaded line that rises slowly, therefore delays the high phase instead of shortening it.

The block runs on a clock at twice the reference rate, so one cycle is half a reference period and the x.5 monitor delays are timed exactly. The line input passes through a synchronizer. Its latency is added to the monitor count, so the level judged is the one on the pin a full monitor delay after release. The pin model outside the block is open drain: `scl_oe` high means the pad pulls SCL low. Data shifting, START/STOP conditions and arbitration belong to neighbouring logic, which uses `bit_tick` to pace itself. The block carries no data stream, so all of its pins are plain control and status.

Top module: `i2c_scl_bitsync`

## Requirements
- R1: During and after reset, with `run` low, `scl_oe` is 0 (line released) and `bit_tick` is 0.
- R2: Each bit begins with a low phase in which `scl_oe` is 1 for exactly LOW_CYC consecutive cycles (default 20).
- R3: The line is not read before the monitor delay has passed. It is measured in cycles of the double-rate clock from the first released cycle and chosen by `rate_sel`: 0 → 15, 1 → 39, 2 → 35, 3 → 83. With the line high from the moment of release, the released part of a bit lasts monitor + 3 + HIGH_CYC cycles.
- R4: `rate_sel` is captured when the low phase ends. A change while the line is released does not alter the current bit's length.
- R5: If the line first reads high at released cycle k, counting from 0, the released part lasts max(monitor, k) + 3 + HIGH_CYC cycles. A rise that happens before the monitor delay expires has no effect on the length.
- R6: `bit_tick` pulses for one cycle in the last released cycle of each bit. If `run` is high in that cycle, `scl_oe` is 1 in the next cycle.
- R7: If `run` is dropped during a bit, that bit completes with its normal length and its tick. After that, `scl_oe` stays 0 and no further tick occurs.
- R8: The high phase (HIGH_CYC cycles, default 20) starts only in the cycle after the synchronized line level reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the reference rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | 2 | Selects the monitor delay |
| run | input | 1 | Start and keep generating bits while high |
| scl_in | input | 1 | Level sampled from the SCL pad |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit |

## Verification
Two events can land in the same cycle: the slave letting go of SCL and the expiry of the monitor delay. The bench provokes this by releasing its hold exactly at the monitor count, and also one cycle after it. It expects the first case to give the same length as an unstretched bit and the second to add exactly one cycle. It also lands a `run` drop and a `rate_sel` change inside the released phase of the bit in flight. It judges these by the measured low and released lengths of that bit and by the quiet line that follows.

// File: rtl/i2c_scl_bitsync_pkg.sv
package i2c_scl_bitsync_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LOW  = 3'd1,
    PH_MON  = 3'd2,
    PH_WAIT = 3'd3,
    PH_HIGH = 3'd4
  } phase_t;

  localparam int MON_W   = 7;
  localparam int MON_MAX = 83;

  // monitor delay in half reference periods
  function automatic logic [MON_W-1:0] mon_half(input logic [1:0] sel);
    case (sel)
      2'd0:    mon_half = 7'd15;
      2'd1:    mon_half = 7'd39;
      2'd2:    mon_half = 7'd35;
      default: mon_half = 7'd83;
    endcase
  endfunction

endpackage

// File: rtl/i2c_scl_in_sync.sv
module i2c_scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_s
);

  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= line_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign line_s = chain[STAGES-1];

endmodule

// File: rtl/i2c_scl_phase_ctrl.sv
module i2c_scl_phase_ctrl
  import i2c_scl_bitsync_pkg::*;
#(
  parameter int LOW_CYC  = 20,
  parameter int HIGH_CYC = 20,
  parameter int SYNC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       run,
  input  logic       line_s,
  output logic       drive_low,
  output logic       tick
);

  localparam int M1   = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int MAXC = (M1 > MON_MAX + SYNC) ? M1 : MON_MAX + SYNC;
  localparam int CW   = $clog2(MAXC + 1);

  phase_t           ph;
  logic [CW-1:0]    cnt;
  logic [MON_W-1:0] mon_lim;
  logic             low_end, mon_end, high_end;

  assign low_end  = (int'(cnt) == LOW_CYC - 1);
  assign mon_end  = (int'(cnt) == int'(mon_lim) + SYNC - 1);
  assign high_end = (int'(cnt) == HIGH_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      mon_lim <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          cnt <= '0;
          if (run) ph <= PH_LOW;
        end
        PH_LOW: begin
          if (low_end) begin
            ph      <= PH_MON;
            cnt     <= '0;
            mon_lim <= mon_half(rate_sel);
          end else cnt <= cnt + 1'b1;
        end
        PH_MON: begin
          if (mon_end) begin
            ph  <= PH_WAIT;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_WAIT: begin
          cnt <= '0;
          if (line_s) ph <= PH_HIGH;
        end
        PH_HIGH: begin
          if (high_end) begin
            ph  <= run ? PH_LOW : PH_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          ph  <= PH_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign drive_low = (ph == PH_LOW);
  assign tick      = (ph == PH_HIGH) && high_end;

  // R3
  mon_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WAIT && $past(ph) == PH_MON) |-> (int'($past(cnt)) == int'(mon_lim) + SYNC - 1));

  // R4
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WAIT || ph == PH_HIGH) |-> $stable(mon_lim));

  // R8
  high_after_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_HIGH && $past(ph) == PH_WAIT) |-> $past(line_s));

  // R6
  tick_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !drive_low);

  // R6
  tick_redrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run) |=> drive_low);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && !run) |=> (!drive_low && !tick));

endmodule

// File: rtl/i2c_scl_bitsync.sv
module i2c_scl_bitsync #(
  parameter int LOW_CYC  = 20,
  parameter int HIGH_CYC = 20,
  parameter int SYNC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       run,
  input  logic       scl_in,
  output logic       scl_oe,
  output logic       bit_tick
);

  logic line_s;

  i2c_scl_in_sync #(.STAGES(SYNC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_raw (scl_in),
    .line_s   (line_s)
  );

  i2c_scl_phase_ctrl #(
    .LOW_CYC  (LOW_CYC),
    .HIGH_CYC (HIGH_CYC),
    .SYNC     (SYNC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .run       (run),
    .line_s    (line_s),
    .drive_low (scl_oe),
    .tick      (bit_tick)
  );

endmodule

// File: tb/sim_i2c_scl_bitsync.sv
`timescale 1ns/1ps
module sim_i2c_scl_bitsync;

  localparam int LOWC  = 20;
  localparam int HIGHC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       run = 1'b0;
  logic       hold = 1'b0;
  logic       scl_in;
  logic       scl_oe, bit_tick;

  int checks = 0;
  int errors = 0;
  int cur_k = 0;
  int exp_low_q[$];
  int exp_rel_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign scl_in = ~scl_oe & ~hold;

  i2c_scl_bitsync #(.LOW_CYC(LOWC), .HIGH_CYC(HIGHC), .SYNC(2)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .run(run),
    .scl_in(scl_in), .scl_oe(scl_oe), .bit_tick(bit_tick)
  );

  function automatic int mon_of(input int s);
    case (s)
      0: return 15;
      1: return 39;
      2: return 35;
      default: return 83;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave / line model: holds SCL low until released cycle cur_k
  int relpos = 0;
  always @(negedge clk) begin
    if (scl_oe) begin
      relpos = 0;
      hold   = (cur_k > 0);
    end else begin
      if (relpos == cur_k) hold = 1'b0;
      relpos++;
    end
  end

  // monitor: measures each bit and compares with the scoreboard
  int  lowc = 0, relc = 0;
  bit  seen_low = 1'b0, after_tick = 1'b0, run_at_tick = 1'b0;
  always @(negedge clk) begin
    if (after_tick) begin
      // R6: redrive follows tick when run is high, else stays released (R7)
      check(scl_oe == run_at_tick, "R6", scl_oe, run_at_tick);
      after_tick = 1'b0;
    end
    if (scl_oe) begin
      lowc++;
      seen_low = 1'b1;
    end else if (seen_low) begin
      relc++;
    end
    if (bit_tick) begin
      if (exp_low_q.size() == 0) begin
        check(1'b0, "R6 unexpected tick", 1, 0);
      end else begin
        int el, er;
        el = exp_low_q.pop_front();
        er = exp_rel_q.pop_front();
        check(lowc == el, "R2 low length", lowc, el);
        check(relc == er, "R3/R5 released length", relc, er);
      end
      lowc = 0; relc = 0; seen_low = 1'b0;
      after_tick  = 1'b1;
      run_at_tick = run;
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!bit_tick);
    #1;
  endtask

  // driver: sets up one bit and pushes its expected lengths
  task automatic send_bit(input int sel, input int k, input int alt_sel, input bit drop_run);
    int m;
    m = mon_of(sel);
    rate_sel = sel[1:0];
    cur_k = k;
    exp_low_q.push_back(LOWC);
    exp_rel_q.push_back(((k > m) ? k : m) + 3 + HIGHC);
    run = 1'b1;
    if (alt_sel >= 0 || drop_run) begin
      do @(negedge clk); while (scl_oe !== 1'b1);
      do @(negedge clk); while (scl_oe !== 1'b0);
      #1;
      if (alt_sel >= 0) rate_sel = alt_sel[1:0]; // R4
      if (drop_run) run = 1'b0;                  // R7
    end
    wait_tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(scl_oe == 1'b0 && bit_tick == 1'b0, "R1 in reset", {scl_oe, bit_tick}, 0);
    rst_n = 1'b1;
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (scl_oe || bit_tick) quiet = 1'b0;
      end
      check(quiet, "R1 after reset", !quiet, 0);
    end
    #1;
    send_bit(0, 0, -1, 0);   // R3 rate 0
    send_bit(0, 0, -1, 0);
    send_bit(1, 0, -1, 0);   // R3 rate 1
    send_bit(2, 0, -1, 0);   // R3 rate 2
    send_bit(3, 0, -1, 0);   // R3 rate 3
    send_bit(0, 10, -1, 0);  // R5 slow rise inside monitor window
    send_bit(0, 15, -1, 0);  // R5 release exactly at monitor expiry
    send_bit(0, 16, -1, 0);  // R5 one cycle past expiry
    send_bit(0, 50, -1, 0);  // R5 / R8 slave stretch
    send_bit(1, 45, -1, 0);  // R5 stretch at rate 1
    send_bit(0, 0, 3, 0);    // R4 rate change while released
    send_bit(2, 0, -1, 1);   // R7 run dropped mid-bit
    cur_k = 0;
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 150; i++) begin
        @(negedge clk);
        if (scl_oe || bit_tick) quiet = 1'b0;
      end
      check(quiet, "R7 line stays released", !quiet, 1);
    end
    check(exp_low_q.size() == 0, "R6 all bits ticked", exp_low_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule